// File: doc/BRIEF.md
# Command Block Completion Status Composer

This block closes out a chain of disk command blocks when the chain reaches its finish command. On a start pulse it samples the raw controller status, the error bits saved by the last status test or transfer, the current field number, the memory-error flag, the link to the next command block, the interrupt mask, the stop control word and the remaining-sector count. From these it builds one final status word and a busy decision. The busy bit tells the host whether processing will continue, so the host can spot a block that was appended to the chain but not picked up.

The block then runs a fixed sequence. It writes the sector count to the command block, but only if a transfer took place. It writes the status word. It ORs the interrupt mask into the shared interrupt flag register in one cycle, with an interrupt request. Finally it either issues the stop word and goes idle, or hands the next-block link out as a fetch request. Memory writes leave through a single address/data port that is held until acknowledged.

Top module: `blkfin_top`

## Requirements
- R1: The final status word carries the sampled field number in bits [15:8]; the raw status bits in that byte never reach it.
- R2: Status bits [4:0] are the saved error bits; raw status bits [4:0] have no effect on the word written.
- R3: Status bit 5 (sector found) copies raw status bit 5 when drive_b is 0 and is 0 when drive_b is 1; all other raw bits are dropped.
- R4: Status bit 7 (busy) is 1 exactly when mem_err is 0, the saved error bits are all zero and next_link is nonzero; a zero link marks the last block.
- R5: Status bit 6 equals mem_err, and a memory error forces bit 7 to 0.
- R6: When field_num differs from the done code (default 8'hFF), sector_count is written to count_addr before the status is written to status_addr; when field_num equals the done code, only the status write occurs.
- R7: While wr_valid is high and wr_ack is low, wr_valid, wr_addr and wr_data hold their values; a write completes on the clock edge where both are high.
- R8: After the status write completes, irq_we and irq_req are high together for exactly one cycle, with irq_wdata equal to irq_in OR the sampled mask.
- R9: In the cycle after the interrupt update, a busy result gives fetch_req with fetch_link equal to the sampled next_link; a non-busy result gives stop_valid with stop_word equal to the sampled stop_cmd; never both.
- R10: done is a one-cycle pulse in the same cycle as R9's outcome, and a start pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a completion sequence (sampled when idle) |
| raw_status | input | 16 | Status read from the disk controller |
| saved_err | input | 5 | Error bits saved by the last test or transfer |
| field_num | input | 8 | Current field number, or the done code |
| drive_b | input | 1 | 1 when the second drive type is attached |
| mem_err | input | 1 | A memory error occurred during the block |
| next_link | input | 16 | Link to the next command block, zero if none |
| irq_mask | input | 16 | Interrupt flags to raise |
| stop_cmd | input | 16 | Control word that halts the controller |
| sector_count | input | 16 | Remaining-sector count |
| count_addr | input | ADDR_W | Address of the sector-count word |
| status_addr | input | ADDR_W | Address of the status word |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 16 | Write data |
| wr_ack | input | 1 | Write accepted |
| irq_in | input | 16 | Current shared interrupt flags |
| irq_we | output | 1 | Update strobe for the interrupt flags |
| irq_wdata | output | 16 | New interrupt flag value |
| irq_req | output | 1 | Interrupt request pulse |
| stop_valid | output | 1 | Stop word is being issued |
| stop_word | output | 16 | Stop word to the controller |
| fetch_req | output | 1 | Fetch the next command block |
| fetch_link | output | 16 | Link of the block to fetch |
| done | output | 1 | Sequence finished |

## Verification
The status composition is tried with raw words full of ones in the field and error positions. This separates splicing from passing raw bits through. The same raw word is sent with each drive type to isolate the sector-found masking. The busy decision is tried with a clean case and then with each of its three blockers in turn: a saved error, a memory error and a zero link. Each of these flips the end of the sequence between fetch and stop. A field number equal to the done code removes the sector-count write, and acknowledge delays of zero and several cycles show the write port holding its values. A second start pulse in the middle of a sequence must leave the expected event stream unchanged.

// File: rtl/blkfin_pkg.sv
package blkfin_pkg;

    localparam int WORD_W  = 16;
    localparam int FIELD_W = 8;
    localparam int ERR_W   = 5;

    localparam int BUSY_BIT   = 7;
    localparam int MEMERR_BIT = 6;
    localparam int SECT_BIT   = 5;

    typedef logic [WORD_W-1:0] word_t;

    // Final status layout; the field positions are read by the host.
    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               busy;
        logic               mem_err;
        logic               sect_found;
        logic [ERR_W-1:0]   err;
    } stat_t;

    localparam word_t SECT_MASK = word_t'(1) << SECT_BIT;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CNT,
        S_STAT,
        S_IRQ,
        S_END
    } seq_state_t;

endpackage

// File: rtl/blkfin_status_compose.sv
module blkfin_status_compose
    import blkfin_pkg::*;
#(
    parameter logic [FIELD_W-1:0] DONE_CODE = 8'hFF
) (
    input  word_t              raw_status,
    input  logic [ERR_W-1:0]   saved_err,
    input  logic [FIELD_W-1:0] field_num,
    input  logic               drive_b,
    input  logic               mem_err,
    input  word_t              next_link,
    output word_t              status_word,
    output logic               busy,
    output logic               has_xfer
);

    stat_t fresh;
    word_t keep;

    always_comb begin
        busy     = !mem_err && (saved_err == '0) && (next_link != '0);
        has_xfer = (field_num != DONE_CODE);
        fresh    = '{field: field_num, busy: busy, mem_err: mem_err,
                     sect_found: 1'b0, err: saved_err};
        keep     = drive_b ? '0 : SECT_MASK;
        status_word = (raw_status & keep) | word_t'(fresh);
    end

endmodule

// File: rtl/blkfin_irq_merge.sv
module blkfin_irq_merge
    import blkfin_pkg::*;
(
    input  word_t irq_in,
    input  word_t mask_q,
    output word_t irq_wdata
);

    always_comb irq_wdata = irq_in | mask_q;

endmodule

// File: rtl/blkfin_seq.sv
module blkfin_seq
    import blkfin_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  word_t             status_in,
    input  logic              busy_in,
    input  logic              has_xfer,
    input  word_t             next_link,
    input  word_t             stop_cmd,
    input  word_t             sector_count,
    input  word_t             irq_mask,
    input  logic [ADDR_W-1:0] count_addr,
    input  logic [ADDR_W-1:0] status_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output word_t             wr_data,
    input  logic              wr_ack,
    output word_t             mask_q,
    output logic              irq_we,
    output logic              irq_req,
    output logic              stop_valid,
    output word_t             stop_word,
    output logic              fetch_req,
    output word_t             fetch_link,
    output logic              done
);

    seq_state_t        state;
    word_t             stat_q, link_q, stop_q, cnt_q;
    logic              busy_q;
    logic [ADDR_W-1:0] cnt_addr_q, stat_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            stat_q      <= '0;
            link_q      <= '0;
            stop_q      <= '0;
            cnt_q       <= '0;
            mask_q      <= '0;
            busy_q      <= 1'b0;
            cnt_addr_q  <= '0;
            stat_addr_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    stat_q      <= status_in;
                    busy_q      <= busy_in;
                    link_q      <= next_link;
                    stop_q      <= stop_cmd;
                    cnt_q       <= sector_count;
                    mask_q      <= irq_mask;
                    cnt_addr_q  <= count_addr;
                    stat_addr_q <= status_addr;
                    state       <= has_xfer ? S_CNT : S_STAT;
                end
                S_CNT:  if (wr_ack) state <= S_STAT;
                S_STAT: if (wr_ack) state <= S_IRQ;
                S_IRQ:  state <= S_END;
                S_END:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_valid   = (state == S_CNT) || (state == S_STAT);
        wr_addr    = (state == S_CNT) ? cnt_addr_q : stat_addr_q;
        wr_data    = (state == S_CNT) ? cnt_q : stat_q;
        irq_we     = (state == S_IRQ);
        irq_req    = (state == S_IRQ);
        done       = (state == S_END);
        stop_valid = done && !busy_q;
        fetch_req  = done && busy_q;
        stop_word  = stop_q;
        fetch_link = link_q;
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_IRQ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(irq_we)); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({stop_valid, fetch_req}) == 1)); // R9

    AST_FETCH_LINK: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_link != '0)); // R4

    AST_MEMERR_NOBUSY: assert property (@(posedge clk) disable iff (rst)
        (state == S_STAT && wr_data[MEMERR_BIT]) |-> !wr_data[BUSY_BIT]); // R5

endmodule

// File: rtl/blkfin_top.sv
module blkfin_top
    import blkfin_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter logic [FIELD_W-1:0] DONE_CODE = 8'hFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [15:0]        raw_status,
    input  logic [4:0]         saved_err,
    input  logic [7:0]         field_num,
    input  logic               drive_b,
    input  logic               mem_err,
    input  logic [15:0]        next_link,
    input  logic [15:0]        irq_mask,
    input  logic [15:0]        stop_cmd,
    input  logic [15:0]        sector_count,
    input  logic [ADDR_W-1:0]  count_addr,
    input  logic [ADDR_W-1:0]  status_addr,
    output logic               wr_valid,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [15:0]        wr_data,
    input  logic               wr_ack,
    input  logic [15:0]        irq_in,
    output logic               irq_we,
    output logic [15:0]        irq_wdata,
    output logic               irq_req,
    output logic               stop_valid,
    output logic [15:0]        stop_word,
    output logic               fetch_req,
    output logic [15:0]        fetch_link,
    output logic               done
);

    word_t status_w;
    word_t mask_q;
    logic  busy_w;
    logic  has_xfer_w;

    blkfin_status_compose #(.DONE_CODE(DONE_CODE)) compose_i (
        .raw_status (raw_status),
        .saved_err  (saved_err),
        .field_num  (field_num),
        .drive_b    (drive_b),
        .mem_err    (mem_err),
        .next_link  (next_link),
        .status_word(status_w),
        .busy       (busy_w),
        .has_xfer   (has_xfer_w)
    );

    blkfin_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .status_in   (status_w),
        .busy_in     (busy_w),
        .has_xfer    (has_xfer_w),
        .next_link   (next_link),
        .stop_cmd    (stop_cmd),
        .sector_count(sector_count),
        .irq_mask    (irq_mask),
        .count_addr  (count_addr),
        .status_addr (status_addr),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_ack      (wr_ack),
        .mask_q      (mask_q),
        .irq_we      (irq_we),
        .irq_req     (irq_req),
        .stop_valid  (stop_valid),
        .stop_word   (stop_word),
        .fetch_req   (fetch_req),
        .fetch_link  (fetch_link),
        .done        (done)
    );

    blkfin_irq_merge merge_i (
        .irq_in   (irq_in),
        .mask_q   (mask_q),
        .irq_wdata(irq_wdata)
    );

endmodule

// File: tb/blkfin_top_tb_top.sv
module blkfin_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CNT_ADDR  = 16'h0040;
    localparam logic [15:0] STAT_ADDR = 16'h0041;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] raw_status = '0;
    logic [4:0]  saved_err = '0;
    logic [7:0]  field_num = '0;
    logic        drive_b = 1'b0;
    logic        mem_err = 1'b0;
    logic [15:0] next_link = '0;
    logic [15:0] irq_mask = '0;
    logic [15:0] stop_cmd = '0;
    logic [15:0] sector_count = '0;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic        wr_ack = 1'b0;
    logic [15:0] irq_in = '0;
    logic        irq_we;
    logic [15:0] irq_wdata;
    logic        irq_req;
    logic        stop_valid;
    logic [15:0] stop_word;
    logic        fetch_req;
    logic [15:0] fetch_link;
    logic        done;

    int checks = 0;
    int failures = 0;
    int ack_delay = 0;
    int dcnt = 0;

    // Scoreboard: kind 0 write (a=addr, b=data), 1 irq (a=wdata),
    // 2 stop (a=stop word, b=2'b01), 3 fetch (a=link, b=2'b10)
    int          q_kind[$];
    logic [15:0] q_a[$];
    logic [15:0] q_b[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    blkfin_top dut_i (
        .clk(clk), .rst(rst), .start(start),
        .raw_status(raw_status), .saved_err(saved_err), .field_num(field_num),
        .drive_b(drive_b), .mem_err(mem_err), .next_link(next_link),
        .irq_mask(irq_mask), .stop_cmd(stop_cmd), .sector_count(sector_count),
        .count_addr(CNT_ADDR), .status_addr(STAT_ADDR),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .irq_in(irq_in), .irq_we(irq_we), .irq_wdata(irq_wdata), .irq_req(irq_req),
        .stop_valid(stop_valid), .stop_word(stop_word),
        .fetch_req(fetch_req), .fetch_link(fetch_link), .done(done)
    );

    task automatic push(input int k, input logic [15:0] a, input logic [15:0] b, input string tag);
        q_kind.push_back(k);
        q_a.push_back(a);
        q_b.push_back(b);
        q_tag.push_back(tag);
    endtask

    task automatic check_item(input int k, input logic [15:0] a, input logic [15:0] b);
        int ek;
        logic [15:0] ea, eb;
        string t;
        checks++;
        if (q_kind.size() == 0) begin
            failures++;
            $display("FAIL R10 unexpected event kind=%0d a=%h b=%h expected none", k, a, b);
        end else begin
            ek = q_kind.pop_front();
            ea = q_a.pop_front();
            eb = q_b.pop_front();
            t  = q_tag.pop_front();
            if (ek != k || ea != a || eb != b) begin
                failures++;
                $display("FAIL %s actual kind=%0d a=%h b=%h expected kind=%0d a=%h b=%h",
                         t, k, a, b, ek, ea, eb);
            end
        end
    endtask

    // Monitor and write acknowledge responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (wr_ack) begin
                    wr_ack = 1'b0;
                    dcnt = ack_delay;
                end else if (wr_valid) begin
                    if (dcnt == 0) begin
                        check_item(0, wr_addr, wr_data);
                        wr_ack = 1'b1;
                    end else begin
                        dcnt--;
                    end
                end
                if (irq_we) begin
                    check_item(1, irq_wdata, 16'h0);
                    checks++;
                    if (!irq_req) begin
                        failures++;
                        $display("FAIL R8 irq_req=%b expected 1", irq_req);
                    end
                end
                if (done) begin
                    if (stop_valid) check_item(2, stop_word, {14'b0, fetch_req, stop_valid});
                    else            check_item(3, fetch_link, {14'b0, fetch_req, stop_valid});
                end
            end
        end
    end

    task automatic run_case(
        input logic [15:0] raw, input logic [4:0] err, input logic [7:0] fld,
        input logic drvb, input logic merr, input logic [15:0] link,
        input logic [15:0] mask, input logic [15:0] stop, input logic [15:0] cnt,
        input logic [15:0] iin, input int delay, input bit restart);
        logic        busy;
        logic        sect;
        logic [15:0] stat;
        busy = !merr && (err == 5'd0) && (link != 16'd0);
        sect = drvb ? 1'b0 : raw[5];
        stat = {fld, busy, merr, sect, err};
        if (fld != 8'hFF) push(0, CNT_ADDR, cnt, "R6 count write");
        push(0, STAT_ADDR, stat, "R1 R2 R3 R4 R5 status write");
        push(1, iin | mask, 16'h0, "R8 interrupt merge");
        if (busy) push(3, link, 16'h0002, "R9 fetch outcome");
        else      push(2, stop, 16'h0001, "R9 stop outcome");

        @(negedge clk);
        ack_delay = delay;
        dcnt = delay;
        raw_status = raw; saved_err = err; field_num = fld; drive_b = drvb;
        mem_err = merr; next_link = link; irq_mask = mask; stop_cmd = stop;
        sector_count = cnt; irq_in = iin;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs: captured values must be used
        raw_status = ~raw; saved_err = ~err; field_num = ~fld; next_link = ~link;
        if (restart) begin
            @(negedge clk);
            start = 1'b1;   // R10: must be ignored mid-sequence
            @(negedge clk);
            start = 1'b0;
        end
        while (q_kind.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        checks++;
        if (done || wr_valid || irq_we) begin
            failures++;
            $display("FAIL R10 activity after done: done=%b wr_valid=%b irq_we=%b expected 0 0 0",
                     done, wr_valid, irq_we);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (wr_valid || done || irq_we || fetch_req || stop_valid) begin
            failures++;
            $display("FAIL R10 reset state wr_valid=%b done=%b irq_we=%b fetch=%b stop=%b expected all 0",
                     wr_valid, done, irq_we, fetch_req, stop_valid);
        end
        // R1 R2 R3 R4: clean, drive A, raw full of ones -> fetch
        run_case(16'hFFFF, 5'd0, 8'h03, 1'b0, 1'b0, 16'h1234, 16'h0010, 16'hA5A5, 16'h0000, 16'h0101, 0, 1'b0);
        // R3: drive B masks sector found
        run_case(16'hFFFF, 5'd0, 8'h02, 1'b1, 1'b0, 16'h0800, 16'h0020, 16'h5A5A, 16'h0002, 16'h0000, 2, 1'b0);
        // R3: drive A with sector found clear in raw
        run_case(16'hFFDF, 5'd0, 8'h01, 1'b0, 1'b0, 16'h0001, 16'h8000, 16'h1111, 16'h0007, 16'h0F00, 1, 1'b0);
        // R2 R4: saved error blocks busy -> stop
        run_case(16'h001F, 5'h11, 8'h03, 1'b0, 1'b0, 16'h2222, 16'h0004, 16'hC0DE, 16'h0003, 16'h0004, 0, 1'b0);
        // R5: memory error forces flag and clears busy
        run_case(16'h0020, 5'd0, 8'h02, 1'b0, 1'b1, 16'h3333, 16'h0001, 16'hBEEF, 16'h0001, 16'h0000, 3, 1'b0);
        // R4: null link marks the last block
        run_case(16'h0000, 5'd0, 8'h01, 1'b0, 1'b0, 16'h0000, 16'h0200, 16'hFACE, 16'h0000, 16'h0002, 0, 1'b0);
        // R6: done code -> no count write
        run_case(16'hFF20, 5'd0, 8'hFF, 1'b0, 1'b0, 16'h4444, 16'h0040, 16'h0F0F, 16'h0009, 16'h0000, 1, 1'b0);
        // R7 R10: long ack delay with a second start mid-sequence
        run_case(16'h0020, 5'h02, 8'h03, 1'b1, 1'b0, 16'h5555, 16'h0003, 16'h7777, 16'h0005, 16'h1000, 4, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule